// File: doc/BRIEF.md
# Overlap-Aware Scan Window Access Sequencer

This block drives a shared image memory for a 3 by 3 neighbourhood filter. It takes one window handle at a time: the upper-left pixel coordinate of the window, whether that handle opens a new scan line, and whether row bursts are allowed. For each handle it spends a fixed loading gap and then issues the reads. It passes every returned word out with the column and row offset it holds inside the window. It then waits for the filtered result and writes it back to the upper-left pixel of the window, which the following steps no longer read, so source and result images can share one buffer.

Every memory access has two phases: an address cycle that carries the strobe, then a data cycle. A burst read has one address cycle followed by three data cycles along a window row. At the first handle of a scan line the whole window is fetched. At every later handle the window has moved one pixel to the right, so two columns are already held downstream and only the rightmost column is read. The image row pitch, coordinate and data widths, window size and loading gap are parameters. Pixel (x, y) sits at word address y * IMG_W + x.

Top module: `scanwin_seq`

## Requirements
- R1: Out of reset, and after any reset during a run, handle_ready is 1 and mem_cmd_rd, mem_cmd_wr, mem_burst, mem_wdata_vld and pix_valid are all 0.
- R2: A handle is taken on a clock edge where handle_valid and handle_ready are both 1. handle_ready then drops and the first read address phase appears exactly LOAD_GAP cycles later (default 4), in cycle LOAD_GAP+1 counted from the accepting edge.
- R3: Every access is two-phase. A cycle with mem_cmd_rd = 1 and mem_burst = 0 is followed by exactly one data cycle. With mem_burst = 1 it is followed by three data cycles that return the addressed word and the next two words.
- R4: At a line-start handle (first_in_line = 1) with burst_mode = 0, nine single reads are made in row-major order: row 0 columns 0,1,2, then row 1, then row 2. They take 18 cycles.
- R5: At a line-start handle with burst_mode = 1, three burst reads are made, one per row from row 0 to row 2, each starting at column 0. They take 12 cycles.
- R6: At an inner handle (first_in_line = 0), only column 2 is read, as three single reads for rows 0, 1, 2 in 6 cycles, whatever the value of burst_mode.
- R7: During each read data cycle pix_valid = 1, pix_col and pix_row give the offset (0..2) inside the window, and pix_data is the memory word at address (y + pix_row) * IMG_W + (x + pix_col).
- R8: The write address phase (mem_cmd_wr = 1) never comes before result_valid. Once all reads are done, it appears in the cycle after the first cycle in which result_valid is 1. With result_valid held at 1, this is cycle LOAD_GAP + read cycles + 2. mem_addr then equals y * IMG_W + x.
- R9: The cycle after the write address phase is the write data phase (mem_wdata_vld = 1). It carries the result_data value present when result_valid was taken, even if result_data changes afterwards.
- R10: handle_valid is ignored while handle_ready is 0. handle_ready returns in the cycle after the write data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| handle_valid | input | 1 | A window handle is offered |
| handle_ready | output | 1 | Sequencer is idle and takes a handle |
| handle_x | input | COORD_W | Window upper-left column |
| handle_y | input | COORD_W | Window upper-left row |
| first_in_line | input | 1 | Handle opens a scan line (no overlap) |
| burst_mode | input | 1 | Allow row bursts at line-start handles |
| result_valid | input | 1 | Filtered result is available |
| result_data | input | DATA_W | Filtered result value |
| mem_addr | output | ADDR_W | Word address during address phases |
| mem_cmd_rd | output | 1 | Read address phase |
| mem_cmd_wr | output | 1 | Write address phase |
| mem_burst | output | 1 | Read address phase opens a three-beat burst |
| mem_rdata | input | DATA_W | Read data from memory in data phases |
| mem_wdata | output | DATA_W | Write data |
| mem_wdata_vld | output | 1 | Write data phase |
| pix_valid | output | 1 | A window pixel is delivered |
| pix_col | output | OFS_W | Column offset of the delivered pixel |
| pix_row | output | OFS_W | Row offset of the delivered pixel |
| pix_data | output | DATA_W | Delivered pixel value |

## Verification
The bench walks handles at the image corners and edges in all three access modes and compares each tagged pixel with the word a model memory holds at the expected address. A sequencer that mixed up the overlap case would fetch nine pixels at inner handles, or a stale column, and its tags or data would disagree. A late result_valid, with result_data changed right after it is taken, exposes a write issued too early or write data not held. Handles offered while busy, and a reset in mid-window, show whether a sequencer swallows a second handle or keeps strobing after reset.

// File: rtl/scanwin_pkg.sv
`timescale 1ns/1ps
package scanwin_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_RADDR,
        ST_RDATA,
        ST_WAIT,
        ST_WADDR,
        ST_WDATA
    } swin_state_e;
endpackage

// File: rtl/scanwin_walk.sv
`timescale 1ns/1ps
// Next window offset for the read walk. Line-start windows go in raster
// order; overlapped windows only step down the rightmost column.
module scanwin_walk #(
    parameter int WIN   = 3,
    parameter int OFS_W = 2
) (
    input  logic [OFS_W-1:0] cur_col,
    input  logic [OFS_W-1:0] cur_row,
    input  logic             full_win,
    output logic [OFS_W-1:0] nxt_col,
    output logic [OFS_W-1:0] nxt_row,
    output logic             row_end,
    output logic             walk_last
);
    localparam logic [OFS_W-1:0] EDGE = OFS_W'(WIN - 1);

    always_comb begin
        row_end   = (cur_col == EDGE);
        walk_last = row_end && (cur_row == EDGE);
        if (full_win) begin
            nxt_col = row_end ? '0 : cur_col + OFS_W'(1);
            nxt_row = row_end ? cur_row + OFS_W'(1) : cur_row;
        end else begin
            nxt_col = EDGE;
            nxt_row = cur_row + OFS_W'(1);
        end
    end
endmodule

// File: rtl/scanwin_addr.sv
`timescale 1ns/1ps
// Linear word address of a window pixel: (y+row)*IMG_W + (x+col).
module scanwin_addr #(
    parameter int COORD_W = 8,
    parameter int OFS_W   = 2,
    parameter int ADDR_W  = 16,
    parameter int IMG_W   = 22
) (
    input  logic [COORD_W-1:0] base_x,
    input  logic [COORD_W-1:0] base_y,
    input  logic [OFS_W-1:0]   ofs_col,
    input  logic [OFS_W-1:0]   ofs_row,
    output logic [ADDR_W-1:0]  word_addr
);
    localparam bit PITCH_POW2 = ((IMG_W & (IMG_W - 1)) == 0);

    logic [ADDR_W-1:0] col_abs;
    logic [ADDR_W-1:0] row_abs;
    logic [ADDR_W-1:0] row_base;

    assign col_abs = ADDR_W'(base_x) + ADDR_W'(ofs_col);
    assign row_abs = ADDR_W'(base_y) + ADDR_W'(ofs_row);

    generate
        if (PITCH_POW2) begin : g_shift
            localparam int PITCH_SH = $clog2(IMG_W);
            assign row_base = row_abs << PITCH_SH;
        end else begin : g_mult
            assign row_base = row_abs * ADDR_W'(IMG_W);
        end
    endgenerate

    assign word_addr = row_base + col_abs;
endmodule

// File: rtl/scanwin_fsm.sv
`timescale 1ns/1ps
module scanwin_fsm
    import scanwin_pkg::*;
#(
    parameter int COORD_W  = 8,
    parameter int OFS_W    = 2,
    parameter int DATA_W   = 16,
    parameter int WIN      = 3,
    parameter int LOAD_GAP = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               handle_valid,
    input  logic [COORD_W-1:0] handle_x,
    input  logic [COORD_W-1:0] handle_y,
    input  logic               first_in_line,
    input  logic               burst_mode,
    input  logic               result_valid,
    input  logic [DATA_W-1:0]  result_data,
    input  logic [DATA_W-1:0]  mem_rdata,
    input  logic [OFS_W-1:0]   nxt_col,
    input  logic [OFS_W-1:0]   nxt_row,
    input  logic               row_end,
    input  logic               walk_last,
    output logic [OFS_W-1:0]   cur_col,
    output logic [OFS_W-1:0]   cur_row,
    output logic               full_win,
    output logic [COORD_W-1:0] base_x,
    output logic [COORD_W-1:0] base_y,
    output logic [OFS_W-1:0]   ofs_col,
    output logic [OFS_W-1:0]   ofs_row,
    output logic               handle_ready,
    output logic               mem_cmd_rd,
    output logic               mem_cmd_wr,
    output logic               mem_burst,
    output logic [DATA_W-1:0]  mem_wdata,
    output logic               mem_wdata_vld,
    output logic               pix_valid,
    output logic [OFS_W-1:0]   pix_col,
    output logic [OFS_W-1:0]   pix_row,
    output logic [DATA_W-1:0]  pix_data
);
    localparam int GAP_W = (LOAD_GAP < 2) ? 1 : $clog2(LOAD_GAP);
    localparam logic [OFS_W-1:0] EDGE = OFS_W'(WIN - 1);

    typedef struct packed {
        swin_state_e        st;
        logic [GAP_W-1:0]   gap;
        logic [COORD_W-1:0] hx;
        logic [COORD_W-1:0] hy;
        logic               full;
        logic               burst;
        logic [OFS_W-1:0]   col;
        logic [OFS_W-1:0]   row;
        logic [DATA_W-1:0]  res;
    } seq_regs_t;

    seq_regs_t regs_d, regs_q;
    logic      burst_act;

    assign burst_act = regs_q.full && regs_q.burst;

    always_comb begin
        regs_d = regs_q;
        unique case (regs_q.st)
            ST_IDLE: begin
                if (handle_valid) begin
                    regs_d.hx    = handle_x;
                    regs_d.hy    = handle_y;
                    regs_d.full  = first_in_line;
                    regs_d.burst = burst_mode;
                    regs_d.col   = first_in_line ? '0 : EDGE;
                    regs_d.row   = '0;
                    regs_d.gap   = GAP_W'(LOAD_GAP - 1);
                    regs_d.st    = ST_LOAD;
                end
            end
            ST_LOAD: begin
                if (regs_q.gap == '0) begin
                    regs_d.st = ST_RADDR;
                end else begin
                    regs_d.gap = regs_q.gap - GAP_W'(1);
                end
            end
            ST_RADDR: regs_d.st = ST_RDATA;
            ST_RDATA: begin
                if (burst_act && !row_end) begin
                    regs_d.col = nxt_col;
                end else if (walk_last) begin
                    regs_d.st = ST_WAIT;
                end else begin
                    regs_d.col = nxt_col;
                    regs_d.row = nxt_row;
                    regs_d.st  = ST_RADDR;
                end
            end
            ST_WAIT: begin
                if (result_valid) begin
                    regs_d.res = result_data;
                    regs_d.st  = ST_WADDR;
                end
            end
            ST_WADDR: regs_d.st = ST_WDATA;
            ST_WDATA: regs_d.st = ST_IDLE;
            default:  regs_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '{st: ST_IDLE, default: '0};
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        cur_col       = regs_q.col;
        cur_row       = regs_q.row;
        full_win      = regs_q.full;
        base_x        = regs_q.hx;
        base_y        = regs_q.hy;
        handle_ready  = (regs_q.st == ST_IDLE);
        mem_cmd_rd    = (regs_q.st == ST_RADDR);
        mem_burst     = (regs_q.st == ST_RADDR) && burst_act;
        mem_cmd_wr    = (regs_q.st == ST_WADDR);
        mem_wdata_vld = (regs_q.st == ST_WDATA);
        mem_wdata     = regs_q.res;
        pix_valid     = (regs_q.st == ST_RDATA);
        pix_col       = regs_q.col;
        pix_row       = regs_q.row;
        pix_data      = mem_rdata;
        if (regs_q.st == ST_WADDR) begin
            ofs_col = '0;
            ofs_row = '0;
        end else begin
            ofs_col = regs_q.col;
            ofs_row = regs_q.row;
        end
    end

    // R2: an accepted handle leaves idle and enters the loading gap
    assert_accept_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (handle_valid && handle_ready) |=> (!handle_ready && !mem_cmd_rd));

    // R3: every read address phase is followed by a data phase
    assert_rd_data_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cmd_rd |=> pix_valid);

    // R5: a burst starts at the leftmost column
    assert_burst_from_left_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_burst |=> (pix_valid && pix_col == '0));

    // R6: overlapped windows deliver only the rightmost column
    assert_inner_column_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !regs_q.full) |-> (pix_col == EDGE));

    // R8: the write address phase follows an observed result
    assert_write_after_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_cmd_wr) |-> $past(result_valid));

    // R9: write data phase follows at once with held data
    assert_wdata_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cmd_wr |=> (mem_wdata_vld && $stable(mem_wdata)));
endmodule

// File: rtl/scanwin_seq.sv
`timescale 1ns/1ps
module scanwin_seq #(
    parameter int COORD_W  = 8,
    parameter int DATA_W   = 16,
    parameter int ADDR_W   = 16,
    parameter int IMG_W    = 22,
    parameter int WIN      = 3,
    parameter int LOAD_GAP = 4,
    parameter int OFS_W    = $clog2(WIN)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               handle_valid,
    output logic               handle_ready,
    input  logic [COORD_W-1:0] handle_x,
    input  logic [COORD_W-1:0] handle_y,
    input  logic               first_in_line,
    input  logic               burst_mode,
    input  logic               result_valid,
    input  logic [DATA_W-1:0]  result_data,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic               mem_cmd_rd,
    output logic               mem_cmd_wr,
    output logic               mem_burst,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic [DATA_W-1:0]  mem_wdata,
    output logic               mem_wdata_vld,
    output logic               pix_valid,
    output logic [OFS_W-1:0]   pix_col,
    output logic [OFS_W-1:0]   pix_row,
    output logic [DATA_W-1:0]  pix_data
);
    logic [OFS_W-1:0]   cur_col, cur_row, nxt_col, nxt_row;
    logic [OFS_W-1:0]   ofs_col, ofs_row;
    logic               full_win, row_end, walk_last;
    logic [COORD_W-1:0] base_x, base_y;

    scanwin_walk #(.WIN(WIN), .OFS_W(OFS_W)) u_walk (
        .cur_col   (cur_col),
        .cur_row   (cur_row),
        .full_win  (full_win),
        .nxt_col   (nxt_col),
        .nxt_row   (nxt_row),
        .row_end   (row_end),
        .walk_last (walk_last)
    );

    scanwin_addr #(.COORD_W(COORD_W), .OFS_W(OFS_W), .ADDR_W(ADDR_W), .IMG_W(IMG_W)) u_addr (
        .base_x    (base_x),
        .base_y    (base_y),
        .ofs_col   (ofs_col),
        .ofs_row   (ofs_row),
        .word_addr (mem_addr)
    );

    scanwin_fsm #(
        .COORD_W(COORD_W), .OFS_W(OFS_W), .DATA_W(DATA_W),
        .WIN(WIN), .LOAD_GAP(LOAD_GAP)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .handle_valid  (handle_valid),
        .handle_x      (handle_x),
        .handle_y      (handle_y),
        .first_in_line (first_in_line),
        .burst_mode    (burst_mode),
        .result_valid  (result_valid),
        .result_data   (result_data),
        .mem_rdata     (mem_rdata),
        .nxt_col       (nxt_col),
        .nxt_row       (nxt_row),
        .row_end       (row_end),
        .walk_last     (walk_last),
        .cur_col       (cur_col),
        .cur_row       (cur_row),
        .full_win      (full_win),
        .base_x        (base_x),
        .base_y        (base_y),
        .ofs_col       (ofs_col),
        .ofs_row       (ofs_row),
        .handle_ready  (handle_ready),
        .mem_cmd_rd    (mem_cmd_rd),
        .mem_cmd_wr    (mem_cmd_wr),
        .mem_burst     (mem_burst),
        .mem_wdata     (mem_wdata),
        .mem_wdata_vld (mem_wdata_vld),
        .pix_valid     (pix_valid),
        .pix_col       (pix_col),
        .pix_row       (pix_row),
        .pix_data      (pix_data)
    );
endmodule

// File: tb/tb_scanwin_seq.sv
`timescale 1ns/1ps
module tb_scanwin_seq;
    localparam int COORD_W  = 8;
    localparam int DATA_W   = 16;
    localparam int ADDR_W   = 16;
    localparam int IMG_W    = 22;
    localparam int WIN      = 3;
    localparam int LOAD_GAP = 4;
    localparam int OFS_W    = 2;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               handle_valid = 1'b0;
    logic               handle_ready;
    logic [COORD_W-1:0] handle_x = '0;
    logic [COORD_W-1:0] handle_y = '0;
    logic               first_in_line = 1'b0;
    logic               burst_mode = 1'b0;
    logic               result_valid = 1'b0;
    logic [DATA_W-1:0]  result_data = '0;
    logic [ADDR_W-1:0]  mem_addr;
    logic               mem_cmd_rd, mem_cmd_wr, mem_burst;
    logic [DATA_W-1:0]  mem_rdata;
    logic [DATA_W-1:0]  mem_wdata;
    logic               mem_wdata_vld;
    logic               pix_valid;
    logic [OFS_W-1:0]   pix_col, pix_row;
    logic [DATA_W-1:0]  pix_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    scanwin_seq #(
        .COORD_W(COORD_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
        .IMG_W(IMG_W), .WIN(WIN), .LOAD_GAP(LOAD_GAP), .OFS_W(OFS_W)
    ) dut (
        .clk(clk), .rst_n(rst_n),
        .handle_valid(handle_valid), .handle_ready(handle_ready),
        .handle_x(handle_x), .handle_y(handle_y),
        .first_in_line(first_in_line), .burst_mode(burst_mode),
        .result_valid(result_valid), .result_data(result_data),
        .mem_addr(mem_addr), .mem_cmd_rd(mem_cmd_rd), .mem_cmd_wr(mem_cmd_wr),
        .mem_burst(mem_burst), .mem_rdata(mem_rdata),
        .mem_wdata(mem_wdata), .mem_wdata_vld(mem_wdata_vld),
        .pix_valid(pix_valid), .pix_col(pix_col), .pix_row(pix_row),
        .pix_data(pix_data)
    );

    function automatic logic [DATA_W-1:0] word_at(input logic [ADDR_W-1:0] a);
        return (a * 16'h9E37) ^ 16'h5A3C;
    endfunction

    // Memory model: a word pointer loaded on a read address phase, advancing each cycle.
    logic [ADDR_W-1:0] rd_ptr;
    always_ff @(posedge clk) begin
        if (!rst_n) rd_ptr <= '0;
        else if (mem_cmd_rd) rd_ptr <= mem_addr;
        else rd_ptr <= rd_ptr + 16'd1;
    end
    assign mem_rdata = word_at(rd_ptr);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    typedef struct packed {
        logic [7:0]  x;
        logic [7:0]  y;
        logic        first;
        logic        burst;
        logic [15:0] res;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{8'd0,  8'd0, 1'b1, 1'b0, 16'h1111},
        '{8'd1,  8'd0, 1'b0, 1'b0, 16'h2222},
        '{8'd2,  8'd0, 1'b0, 1'b1, 16'h3333},
        '{8'd0,  8'd1, 1'b1, 1'b1, 16'h4444},
        '{8'd19, 8'd8, 1'b0, 1'b1, 16'hBEEF},
        '{8'd5,  8'd3, 1'b1, 1'b0, 16'h0F0F},
        '{8'd19, 8'd8, 1'b1, 1'b1, 16'hFFFF},
        '{8'd0,  8'd8, 1'b0, 1'b0, 16'h0000}
    };

    // One window. res_delay = 0: result_valid held from the start.
    // res_delay > 0: result_valid raised res_delay cycles after reads end.
    task automatic run_window(input int x, input int y, input bit first, input bit burst,
                              input logic [15:0] res, input int res_delay, input bit poke);
        int rd_cyc = first ? (burst ? 4 * WIN : 2 * WIN * WIN) : 2 * WIN;
        int raise_cyc = LOAD_GAP + rd_cyc + 1 + res_delay;
        int cyc = 1;
        int nrd = 0, nbst = 0, npix = 0, nwr = 0;
        int first_rd = -1, wr_cyc = -1, wd_cyc = -1, rdy_cyc = -1;
        logic [ADDR_W-1:0] wr_addr = '0;
        logic [DATA_W-1:0] wdat = '0;
        bit done = 1'b0;
        string preq = first ? (burst ? "R5" : "R4") : "R6";

        @(negedge clk);
        chk(handle_ready == 1'b1, "R10", "ready before handle", 32'(handle_ready), 32'd1);
        handle_x      = 8'(x);
        handle_y      = 8'(y);
        first_in_line = first;
        burst_mode    = burst;
        result_data   = res;
        result_valid  = (res_delay == 0);
        handle_valid  = 1'b1;
        @(negedge clk);
        handle_valid = poke;
        if (poke) begin
            handle_x = 8'd7;
            handle_y = 8'd2;
            first_in_line = ~first;
        end
        while (!done && cyc < 400) begin
            if (poke && cyc == LOAD_GAP + rd_cyc) handle_valid = 1'b0;
            if (mem_cmd_rd) begin
                nrd++;
                if (first_rd < 0) first_rd = cyc;
                if (mem_burst) nbst++;
            end
            if (pix_valid) begin
                int ec = first ? (npix % WIN) : (WIN - 1);
                int er = first ? (npix / WIN) : npix;
                logic [DATA_W-1:0] ed = word_at(ADDR_W'((y + er) * IMG_W + x + ec));
                chk(pix_col == OFS_W'(ec) && pix_row == OFS_W'(er) && pix_data == ed,
                    (npix == 0) ? "R7" : preq, "pixel {col,row,data}",
                    {12'd0, pix_col, pix_row, pix_data}, {12'd0, OFS_W'(ec), OFS_W'(er), ed});
                npix++;
            end
            if (mem_cmd_wr) begin
                nwr++;
                wr_cyc = cyc;
                wr_addr = mem_addr;
            end
            if (mem_wdata_vld) begin
                wd_cyc = cyc;
                wdat = mem_wdata;
            end
            if (res_delay > 0 && cyc == raise_cyc) result_valid = 1'b1;
            if (res_delay > 0 && cyc == raise_cyc + 1) result_data = ~res;
            if (handle_ready && cyc > 1) begin
                rdy_cyc = cyc;
                done = 1'b1;
            end else begin
                @(negedge clk);
                cyc++;
            end
        end
        result_valid = 1'b0;
        handle_valid = 1'b0;

        begin
            int exp_wr = (res_delay == 0) ? (LOAD_GAP + rd_cyc + 2) : (raise_cyc + 1);
            int exp_nrd = first ? (burst ? WIN : WIN * WIN) : WIN;
            int exp_nbst = (first && burst) ? WIN : 0;
            int exp_npix = first ? WIN * WIN : WIN;
            chk(first_rd == LOAD_GAP + 1, "R2", "first read cycle", 32'(first_rd), 32'(LOAD_GAP + 1));
            chk(nrd == exp_nrd, preq, "read address phases", 32'(nrd), 32'(exp_nrd));
            chk(nbst == exp_nbst, "R3", "burst address phases", 32'(nbst), 32'(exp_nbst));
            chk(npix == exp_npix, preq, "pixels delivered", 32'(npix), 32'(exp_npix));
            chk(nwr == 1 && wr_cyc == exp_wr, "R8", "write address cycle", 32'(wr_cyc), 32'(exp_wr));
            chk(wr_addr == ADDR_W'(y * IMG_W + x), "R8", "write address",
                32'(wr_addr), 32'(y * IMG_W + x));
            chk(wd_cyc == exp_wr + 1 && wdat == res, "R9", "write data",
                32'(wdat), 32'(res));
            chk(rdy_cyc == exp_wr + 2, "R10", "ready return cycle", 32'(rdy_cyc), 32'(exp_wr + 2));
        end
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(handle_ready == 1'b1, "R1", "ready in reset", 32'(handle_ready), 32'd1);
        chk(!mem_cmd_rd && !mem_cmd_wr && !mem_burst && !mem_wdata_vld && !pix_valid,
            "R1", "strobes in reset",
            {27'd0, mem_cmd_rd, mem_cmd_wr, mem_burst, mem_wdata_vld, pix_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(handle_ready == 1'b1, "R1", "ready after reset", 32'(handle_ready), 32'd1);

        // Vector table: R4, R5, R6, R7 across modes and image positions
        for (int i = 0; i < NVEC; i++) begin
            run_window(int'(VECS[i].x), int'(VECS[i].y), VECS[i].first, VECS[i].burst,
                       VECS[i].res, 0, 1'b0);
        end

        // R8/R9: late result at a burst line-start and at an inner window
        run_window(3, 2, 1'b1, 1'b1, 16'hA5A5, 7, 1'b0);
        run_window(4, 2, 1'b0, 1'b0, 16'h5A5A, 1, 1'b0);

        // R10: handles offered while busy are ignored
        run_window(10, 5, 1'b1, 1'b0, 16'hC0DE, 0, 1'b1);
        @(negedge clk);
        chk(handle_ready == 1'b1, "R10", "idle after busy offers", 32'(handle_ready), 32'd1);

        // R1: reset in the middle of a window
        handle_x = 8'd6; handle_y = 8'd4; first_in_line = 1'b1; burst_mode = 1'b1;
        handle_valid = 1'b1;
        @(negedge clk);
        handle_valid = 1'b0;
        repeat (LOAD_GAP + 3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(handle_ready == 1'b1, "R1", "ready after mid-run reset", 32'(handle_ready), 32'd1);
        repeat (5) begin
            chk(!mem_cmd_rd && !pix_valid && !mem_cmd_wr, "R1", "quiet after mid-run reset",
                {29'd0, mem_cmd_rd, pix_valid, mem_cmd_wr}, 32'd0);
            @(negedge clk);
        end

        // Sequence resumes normally after the reset
        run_window(18, 7, 1'b0, 1'b1, 16'h7777, 0, 1'b0);

        finish_run();
    end
endmodule